// File: doc/BRIEF.md
# Iterative Integer Multiply-Divide Unit

This unit performs 32-bit integer multiplication and division for a processor core. A caller presents two operands and a two-bit operation code, then pulses `start`. The unit can run a signed multiply, an unsigned multiply, a signed divide or an unsigned divide. It runs a shift-add loop for multiplication and a restoring shift-subtract loop for division. Each loop takes one cycle per operand bit. At the end it writes a 64-bit result into a pair of result registers, HI and LO. A multiply leaves the upper half of the product in HI and the lower half in LO. A divide leaves the quotient in LO and the remainder in HI, so that dividend = quotient × divisor + remainder.

The datapath has no write path into HI and LO. They can only be read through a single move-from port, where `rd_sel` chooses HI or LO. A read request made while the unit is busy stalls: `rd_valid` stays low until the pending operation has written its result. Division by zero does not fault. It completes normally with a fixed result and a one-cycle flag.

The controller has four states. IDLE waits for `start`, then moves to MUL_LOOP when op[1] is 0 or to DIV_LOOP when op[1] is 1. MUL_LOOP and DIV_LOOP each run WIDTH iterations and then move to COMMIT. COMMIT writes HI/LO and returns to IDLE.

Top module: `muldiv_unit`

## Requirements
- R1: After reset, HI and LO read as zero, and `busy`, `done` and `div_zero` are low.
- R2: Operation code 2'b00 (signed multiply) leaves the upper 32 bits of the two's-complement 64-bit product in HI and the lower 32 bits in LO.
- R3: Operation code 2'b01 (unsigned multiply) leaves the 64-bit unsigned product in HI:LO. HI is zero exactly when the product fits in 32 bits.
- R4: Operation code 2'b11 (unsigned divide) with a non-zero divisor leaves the quotient in LO and the remainder in HI.
- R5: Operation code 2'b10 (signed divide) with a non-zero divisor truncates the quotient toward zero and gives the remainder the sign of the dividend. The case -2^31 / -1 yields quotient 0x80000000 and remainder 0.
- R6: A divide by zero, signed or unsigned, yields LO = all ones and HI = the dividend. `div_zero` is high for exactly the one cycle in which `done` is high.
- R7: `busy` rises in the cycle after `start` is accepted and stays high for exactly WIDTH+1 cycles. `done` is high for one cycle, the cycle right after `busy` falls, and is never high together with `busy`.
- R8: A `start` pulse while `busy` is high is ignored. The running operation's result and its timing are unchanged.
- R9: `rd_valid` is low whenever `busy` is high. When `rd_req` is high and `busy` is low, `rd_valid` is high and `rd_data` shows HI if `rd_sel` = 1 or LO if `rd_sel` = 0.
- R10: HI and LO change only when an operation completes. While `busy` is high, `rd_data` still shows the previous result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (accepted only in IDLE) |
| op | input | 2 | Operation: 00 signed mul, 01 unsigned mul, 10 signed div, 11 unsigned div |
| opa | input | 32 | First operand (multiplicand or dividend) |
| opb | input | 32 | Second operand (multiplier or divisor) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse when HI/LO have been written |
| div_zero | output | 1 | One-cycle pulse with `done` when the divisor was zero |
| rd_req | input | 1 | Move-from request |
| rd_sel | input | 1 | 1 selects HI, 0 selects LO |
| rd_valid | output | 1 | Read data is valid (low while busy) |
| rd_data | output | 32 | Selected result register |

## Verification
The bench builds the unit with WIDTH = 32, the width of the target processor. This lets the reference model compute exact products, quotients and remainders in 64-bit arithmetic. It also brings the extreme operands within reach: the most negative value, all ones, one, and zero. With those operands the bench exercises the -2^31 / -1 wrap and the divide-by-zero path in both signed modes. At this width the busy window is 33 cycles. That window is long enough to inject stray `start` pulses and stalled reads in the middle of an operation and to observe that the old result is still visible.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

    typedef enum logic [1:0] {
        OP_MUL  = 2'b00,
        OP_MULU = 2'b01,
        OP_DIV  = 2'b10,
        OP_DIVU = 2'b11
    } md_op_e;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'b00,
        ST_MUL_LOOP = 2'b01,
        ST_DIV_LOOP = 2'b10,
        ST_COMMIT   = 2'b11
    } md_state_e;

endpackage

// File: rtl/muldiv_ctrl.sv
module muldiv_ctrl
    import muldiv_pkg::*;
#(
    parameter int W = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic is_div,
    output logic load,
    output logic step_mul,
    output logic step_div,
    output logic commit,
    output logic busy
);
    localparam int CW = (W > 1) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    md_state_e     state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic          last_iter;

    assign last_iter = (cnt_q == LAST);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // iteration counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= '0;
        end else if (step_mul || step_div) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (start) state_d = is_div ? ST_DIV_LOOP : ST_MUL_LOOP;
            ST_MUL_LOOP: if (last_iter) state_d = ST_COMMIT;
            ST_DIV_LOOP: if (last_iter) state_d = ST_COMMIT;
            ST_COMMIT:   state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        load     = 1'b0;
        step_mul = 1'b0;
        step_div = 1'b0;
        commit   = 1'b0;
        busy     = 1'b1;
        unique case (state_q)
            ST_IDLE: begin
                busy = 1'b0;
                load = start;
            end
            ST_MUL_LOOP: step_mul = 1'b1;
            ST_DIV_LOOP: step_div = 1'b1;
            ST_COMMIT:   commit   = 1'b1;
        endcase
    end

endmodule

// File: rtl/muldiv_datapath.sv
module muldiv_datapath #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [1:0]   op,
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    input  logic         step_mul,
    input  logic         step_div,
    output logic [W-1:0] fin_hi,
    output logic [W-1:0] fin_lo,
    output logic         fin_dz
);
    localparam int W2 = 2 * W;

    logic [W2-1:0] work_q;     // mul: running product; div: {remainder, quotient}
    logic [W-1:0]  oper_q;     // multiplicand or divisor magnitude
    logic [W-1:0]  dvd_q;      // original dividend for divide-by-zero
    logic          is_div_q, neg_main_q, neg_rem_q;

    logic          sgn;
    logic          a_neg, b_neg;
    logic [W-1:0]  a_mag, b_mag;

    assign sgn   = ~op[0];
    assign a_neg = sgn & opa[W-1];
    assign b_neg = sgn & opb[W-1];
    assign a_mag = a_neg ? (~opa + 1'b1) : opa;
    assign b_mag = b_neg ? (~opb + 1'b1) : opb;

    // shift-add step
    logic [W:0]    add_sum;
    assign add_sum = {1'b0, work_q[W2-1:W]} + (work_q[0] ? {1'b0, oper_q} : {(W+1){1'b0}});

    // restoring shift-subtract step
    logic [W:0]    shifted;
    logic [W+1:0]  diff;
    logic          diff_neg;
    assign shifted  = {work_q[W2-1:W], work_q[W-1]};
    assign diff     = {1'b0, shifted} - {2'b00, oper_q};
    assign diff_neg = diff[W+1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            work_q     <= '0;
            oper_q     <= '0;
            dvd_q      <= '0;
            is_div_q   <= 1'b0;
            neg_main_q <= 1'b0;
            neg_rem_q  <= 1'b0;
        end else if (load) begin
            work_q     <= {{W{1'b0}}, a_mag};
            oper_q     <= b_mag;
            dvd_q      <= opa;
            is_div_q   <= op[1];
            neg_main_q <= a_neg ^ b_neg;
            neg_rem_q  <= a_neg;
        end else if (step_mul) begin
            work_q <= {add_sum, work_q[W-1:1]};
        end else if (step_div) begin
            if (diff_neg) begin
                work_q <= {shifted[W-1:0], work_q[W-2:0], 1'b0};
            end else begin
                work_q <= {diff[W-1:0], work_q[W-2:0], 1'b1};
            end
        end
    end

    // final sign correction
    logic [W2-1:0] prod_fix;
    logic [W-1:0]  quo_fix, rem_fix;
    assign prod_fix = neg_main_q ? (~work_q + 1'b1) : work_q;
    assign quo_fix  = neg_main_q ? (~work_q[W-1:0] + 1'b1) : work_q[W-1:0];
    assign rem_fix  = neg_rem_q  ? (~work_q[W2-1:W] + 1'b1) : work_q[W2-1:W];

    assign fin_dz = is_div_q && (oper_q == '0);

    always_comb begin
        if (!is_div_q) begin
            fin_hi = prod_fix[W2-1:W];
            fin_lo = prod_fix[W-1:0];
        end else if (fin_dz) begin
            fin_hi = dvd_q;
            fin_lo = '1;
        end else begin
            fin_hi = rem_fix;
            fin_lo = quo_fix;
        end
    end

endmodule

// File: rtl/muldiv_result.sv
module muldiv_result #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         commit,
    input  logic         busy,
    input  logic [W-1:0] fin_hi,
    input  logic [W-1:0] fin_lo,
    input  logic         fin_dz,
    input  logic         rd_req,
    input  logic         rd_sel,
    output logic         rd_valid,
    output logic [W-1:0] rd_data,
    output logic         done,
    output logic         div_zero,
    output logic [W-1:0] hi_val,
    output logic [W-1:0] lo_val
);
    logic [W-1:0] hi_q, lo_q;
    logic         done_q, dz_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q   <= '0;
            lo_q   <= '0;
            done_q <= 1'b0;
            dz_q   <= 1'b0;
        end else begin
            done_q <= commit;
            dz_q   <= commit & fin_dz;
            if (commit) begin
                hi_q <= fin_hi;
                lo_q <= fin_lo;
            end
        end
    end

    assign rd_valid = rd_req & ~busy;
    assign rd_data  = rd_sel ? hi_q : lo_q;
    assign done     = done_q;
    assign div_zero = dz_q;
    assign hi_val   = hi_q;
    assign lo_val   = lo_q;

endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
    import muldiv_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [1:0]       op,
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    output logic             busy,
    output logic             done,
    output logic             div_zero,
    input  logic             rd_req,
    input  logic             rd_sel,
    output logic             rd_valid,
    output logic [WIDTH-1:0] rd_data
);
    logic             load, step_mul, step_div, commit;
    logic [WIDTH-1:0] fin_hi, fin_lo, hi_val, lo_val;
    logic             fin_dz;

    muldiv_ctrl #(.W(WIDTH)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .is_div   (op[1]),
        .load     (load),
        .step_mul (step_mul),
        .step_div (step_div),
        .commit   (commit),
        .busy     (busy)
    );

    muldiv_datapath #(.W(WIDTH)) u_dp (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .op       (op),
        .opa      (opa),
        .opb      (opb),
        .step_mul (step_mul),
        .step_div (step_div),
        .fin_hi   (fin_hi),
        .fin_lo   (fin_lo),
        .fin_dz   (fin_dz)
    );

    muldiv_result #(.W(WIDTH)) u_res (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit   (commit),
        .busy     (busy),
        .fin_hi   (fin_hi),
        .fin_lo   (fin_lo),
        .fin_dz   (fin_dz),
        .rd_req   (rd_req),
        .rd_sel   (rd_sel),
        .rd_valid (rd_valid),
        .rd_data  (rd_data),
        .done     (done),
        .div_zero (div_zero),
        .hi_val   (hi_val),
        .lo_val   (lo_val)
    );

endmodule

// File: rtl/muldiv_checker.sv
module muldiv_checker #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         busy,
    input logic         done,
    input logic         div_zero,
    input logic         rd_valid,
    input logic [W-1:0] hi_val,
    input logic [W-1:0] lo_val
);
    localparam int LW = $clog2(W + 2) + 1;
    logic [LW-1:0] busy_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     busy_len <= '0;
        else if (busy)  busy_len <= busy_len + 1'b1;
        else            busy_len <= '0;
    end

    AST_BUSY_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (busy_len == LW'(W + 1))); // R7
    AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done); // R7
    AST_DONE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R7
    AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start)); // R8
    AST_DZ_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        div_zero |-> done); // R6
    AST_READ_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !rd_valid); // R9
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(hi_val) && $stable(lo_val))); // R10

endmodule

bind muldiv_unit muldiv_checker #(.W(WIDTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .div_zero (div_zero),
    .rd_valid (rd_valid),
    .hi_val   (hi_val),
    .lo_val   (lo_val)
);

// File: tb/tb_muldiv_unit.sv
module tb_muldiv_unit;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [1:0]   op = 2'b00;
    logic [W-1:0] opa = '0, opb = '0;
    logic         busy, done, div_zero;
    logic         rd_req = 1'b0, rd_sel = 1'b0;
    logic         rd_valid;
    logic [W-1:0] rd_data;

    int n_checks = 0;
    int n_fail   = 0;
    logic [W-1:0] prev_hi = '0, prev_lo = '0;

    always #5 clk = ~clk;

    muldiv_unit #(.WIDTH(W)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .opa(opa), .opb(opb),
        .busy(busy), .done(done), .div_zero(div_zero),
        .rd_req(rd_req), .rd_sel(rd_sel), .rd_valid(rd_valid), .rd_data(rd_data)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] model(input logic [1:0] o, input logic [W-1:0] a,
                                          input logic [W-1:0] b);
        logic signed [63:0] sa, sb, sq, sr;
        logic [63:0] ua, ub;
        sa = {{32{a[W-1]}}, a};
        sb = {{32{b[W-1]}}, b};
        ua = {32'd0, a};
        ub = {32'd0, b};
        case (o)
            2'b00: return sa * sb;
            2'b01: return ua * ub;
            default: begin
                if (b == '0) return {a, 32'hFFFF_FFFF};
                if (o == 2'b11) begin
                    return {(a % b), (a / b)};
                end
                sq = sa / sb;
                sr = sa % sb;
                return {sr[31:0], sq[31:0]};
            end
        endcase
    endfunction

    // run one operation with full protocol checks; inj = inject stray start mid-run
    task automatic run_op(input logic [1:0] o, input logic [W-1:0] a, input logic [W-1:0] b,
                          input bit inj, input string req);
        logic [63:0] exp;
        int bcnt;
        exp = model(o, a, b);
        @(negedge clk);
        op = o; opa = a; opb = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R7 busy after start", {63'd0, busy}, 64'd1);
        bcnt = 0;
        while (busy && bcnt < 100) begin
            bcnt++;
            if (bcnt == 5) begin
                rd_req = 1'b1; rd_sel = 1'b1;
                #1;
                chk("R9 stall while busy", {63'd0, rd_valid}, 64'd0);
                chk("R10 old HI visible", {32'd0, rd_data}, {32'd0, prev_hi});
                rd_sel = 1'b0;
                #1;
                chk("R10 old LO visible", {32'd0, rd_data}, {32'd0, prev_lo});
                rd_req = 1'b0;
            end
            if (inj && bcnt == 10) begin
                op = ~o; opa = ~a; opb = b + 1; start = 1'b1;
            end
            if (inj && bcnt == 11) start = 1'b0;
            chk("R7 done low while busy", {63'd0, done}, 64'd0);
            @(negedge clk);
        end
        chk("R7 busy length", 64'(bcnt), 64'(W + 1));
        chk("R7 done pulse", {63'd0, done}, 64'd1);
        chk("R6 div_zero flag", {63'd0, div_zero},
            {63'd0, (o[1] && b == '0)});
        rd_req = 1'b1; rd_sel = 1'b1;
        #1;
        chk("R9 valid when idle", {63'd0, rd_valid}, 64'd1);
        chk({req, " HI"}, {32'd0, rd_data}, {32'd0, exp[63:32]});
        rd_sel = 1'b0;
        #1;
        chk({req, " LO"}, {32'd0, rd_data}, {32'd0, exp[31:0]});
        rd_req = 1'b0;
        prev_hi = exp[63:32];
        prev_lo = exp[31:0];
        @(negedge clk);
        chk("R7 done one cycle", {63'd0, done}, 64'd0);
        chk("R6 dz one cycle", {63'd0, div_zero}, 64'd0);
    endtask

    function automatic string tag(input logic [1:0] o);
        case (o)
            2'b00: return "R2 signed mul";
            2'b01: return "R3 unsigned mul";
            2'b10: return "R5 signed div";
            default: return "R4 unsigned div";
        endcase
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin : stim
        int seed;
        logic [W-1:0] ra, rb;
        logic [1:0] ro;
        seed = 32'h1F2E3D4C;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 busy", {63'd0, busy}, 64'd0);
        chk("R1 done", {63'd0, done}, 64'd0);
        chk("R1 div_zero", {63'd0, div_zero}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        rd_req = 1'b1; rd_sel = 1'b1;
        #1;
        chk("R1 HI zero", {32'd0, rd_data}, 64'd0);
        rd_sel = 1'b0;
        #1;
        chk("R1 LO zero", {32'd0, rd_data}, 64'd0);
        rd_req = 1'b0;

        // directed corners
        run_op(2'b00, 32'hFFFF_FFF8, 32'd7, 0, "R2 neg x pos");
        run_op(2'b00, 32'h8000_0000, 32'h8000_0000, 0, "R2 min x min");
        run_op(2'b01, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, "R3 max x max");
        run_op(2'b01, 32'd65535, 32'd65537, 0, "R3 fits, HI zero");
        run_op(2'b01, 32'd65536, 32'd65536, 0, "R3 overflows, HI nonzero");
        run_op(2'b11, 32'd78, 32'd21, 0, "R4 78/21");
        run_op(2'b11, 32'hFFFF_FFFF, 32'd1, 0, "R4 max/1");
        run_op(2'b10, 32'hFFFF_FFB2, 32'd21, 0, "R5 -78/21");
        run_op(2'b10, 32'd78, 32'hFFFF_FFEB, 0, "R5 78/-21");
        run_op(2'b10, 32'h8000_0000, 32'hFFFF_FFFF, 0, "R5 min/-1");
        run_op(2'b11, 32'h1234_5678, 32'd0, 0, "R6 unsigned div by zero");
        run_op(2'b10, 32'hF000_0001, 32'd0, 0, "R6 signed div by zero");
        run_op(2'b01, 32'd12345, 32'd6789, 1, "R8 stray start ignored");
        run_op(2'b10, 32'hDEAD_BEEF, 32'd977, 1, "R8 stray start ignored div");

        // constrained random
        for (int i = 0; i < 160; i++) begin
            ro = 2'($urandom_range(0, 3));
            ra = $urandom;
            rb = $urandom;
            case ($urandom_range(0, 5))
                0: rb = rb & 32'h0000_00FF;
                1: ra = 32'h8000_0000;
                2: rb = 32'hFFFF_FFFF;
                default: ;
            endcase
            run_op(ro, ra, rb, (i % 7) == 3, tag(ro));
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule